// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block gathers level-sensitive interrupt requests from a parameterized set of sources. Each source has a default count of 71 slots. The block delivers them to two interrupt outputs, and each output serves one processing target. Every source has its own request register. The register holds a four-bit priority, an enable, a target select and a polarity bit. Each of those fields changes only when its own write-enable bit is set in the same write word. A stray write therefore cannot disturb settings that the writer did not mean to touch.

For each target the block looks at every source that meets three conditions: it is enabled, its polarity-corrected input is asserted, and its priority is strictly above that target's threshold. From these candidates it picks a winner and registers it. The winning index raises the target's output. It can also be read back through a vector register. The vector returns the index multiplied by eight and added to a programmable table base, so software can jump straight to a handler slot. Slot 0 is reserved, so a vector equal to the bare base means no request is pending.

Access goes through a simple synchronous port. There is one shared address, a write strobe and a read strobe, and read data arrives one clock after the read strobe.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset both interrupt outputs are low, and every request, threshold and base register reads as zero.
- R2: Slot 0 is reserved. Writes to address 0 have no effect, address 0 reads zero, and a request on input 0 never raises an output and never appears in a vector.
- R3: A request register at address n (1..70) reads priority in bits 3:0, enable in bit 16, active-low in bit 17 and target in bit 24. All other bits read zero, including the write-enable positions 25 to 28. Writing 0x1E000000 clears all four fields.
- R4: The priority field takes the written bits 3:0 only when bit 28 of that write is 1; otherwise it keeps its value.
- R5: The enable field takes written bit 16 only when bit 26 of that write is 1; otherwise it keeps its value.
- R6: The target field (bit 24) updates only when bit 25 is 1, and the active-low field (bit 17) updates only when bit 27 is 1.
- R7: A source is a candidate for a target only if it is enabled, its corrected input is 1, its target field selects that target, and its priority is strictly greater than that target's threshold. Priority 0 is never delivered.
- R8: Among the candidates of a target, the highest priority wins. On equal priority the lowest source index wins.
- R9: Target field 0 routes to irq_out[0] and 1 to irq_out[1]. Each target has its own threshold register at address 0xC0+t, held in bits 3:0.
- R10: Writing address 0xD0+t sets that target's table base. Reading it returns base + 8 × winning index, or the bare base when there is no winner.
- R11: An output and its vector follow a change of input or register one clock later. An output drops in the clock after its last candidate disappears. Read data is valid in the clock after the read strobe.
- R12: When the active-low bit is 1 the raw input is inverted before arbitration, so a low input requests and a high input does not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | Raw level request per source slot |
| wr_en | input | 1 | Write strobe for addr/wdata |
| rd_en | input | 1 | Read strobe; rdata valid next clock |
| addr | input | ADDR_W | Register address shared by read and write |
| wdata | input | DATA_W | Write data including write-enable bits |
| rdata | output | DATA_W | Registered read data |
| irq_out | output | NUM_TGT | Interrupt request per target |

## Verification
The checks that run on every cycle cover the per-field write locks for priority, enable and polarity. They also confirm that a raised output names a winner which was a real candidate one clock earlier, that no better or equal lower-index candidate was passed over, and that an output drops once no candidate remains. Other behaviour only shows up in the bench's scenarios. That covers the exact read-back encoding of request registers, the vector arithmetic against a nonzero base, and the bare-base value when nothing is pending. It also covers the one-clock delay seen at the pins, the reserved slot 0, and the clearing effect of the combined unlock write.

// File: rtl/irq_pkg.sv
package irq_pkg;
   // request register field positions
   localparam int unsigned F_EN    = 16;
   localparam int unsigned F_POL   = 17;
   localparam int unsigned F_TGT   = 24;
   // write-enable (unlock) positions
   localparam int unsigned WE_TGT  = 25;
   localparam int unsigned WE_EN   = 26;
   localparam int unsigned WE_POL  = 27;
   localparam int unsigned WE_PRIO = 28;
   // vector stride as a shift
   localparam int unsigned VEC_SHIFT = 3;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
   parameter int unsigned NUM_SRC = 71,
   parameter int unsigned PRIO_W  = 4,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 32
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [ADDR_W-1:0]              addr,
   input  logic [DATA_W-1:0]              wdata,
   output logic [NUM_SRC-1:0][PRIO_W-1:0] src_prio,
   output logic [NUM_SRC-1:0]             src_en,
   output logic [NUM_SRC-1:0]             src_pol,
   output logic [NUM_SRC-1:0]             src_tgt
);
   import irq_pkg::*;

   // slot 0 is reserved and holds constant zero
   assign src_prio[0] = '0;
   assign src_en[0]   = 1'b0;
   assign src_pol[0]  = 1'b0;
   assign src_tgt[0]  = 1'b0;

   for (genvar s = 1; s < NUM_SRC; s++) begin : g_slot
      logic hit;
      assign hit = wr_en && (addr == ADDR_W'(s));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            src_prio[s] <= '0;
            src_en[s]   <= 1'b0;
            src_pol[s]  <= 1'b0;
            src_tgt[s]  <= 1'b0;
         end else if (hit) begin
            if (wdata[WE_PRIO]) src_prio[s] <= wdata[PRIO_W-1:0];
            if (wdata[WE_EN])   src_en[s]   <= wdata[F_EN];
            if (wdata[WE_POL])  src_pol[s]  <= wdata[F_POL];
            if (wdata[WE_TGT])  src_tgt[s]  <= wdata[F_TGT];
         end
      end
   end
endmodule

// File: rtl/irq_tgt_cfg.sv
module irq_tgt_cfg #(
   parameter int unsigned PRIO_W   = 4,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned THR_ADDR = 8'hC0,
   parameter int unsigned VEC_ADDR = 8'hD0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [PRIO_W-1:0] thr,
   output logic [DATA_W-1:0] base
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         thr  <= '0;
         base <= '0;
      end else if (wr_en) begin
         if (addr == ADDR_W'(THR_ADDR)) thr  <= wdata[PRIO_W-1:0];
         if (addr == ADDR_W'(VEC_ADDR)) base <= wdata;
      end
   end
endmodule

// File: rtl/irq_tgt_arb.sv
module irq_tgt_arb #(
   parameter int unsigned NUM_SRC = 71,
   parameter int unsigned PRIO_W  = 4,
   parameter int unsigned TGT     = 0,
   localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_SRC-1:0]             lvl,
   input  logic [NUM_SRC-1:0]             src_en,
   input  logic [NUM_SRC-1:0]             src_tgt,
   input  logic [NUM_SRC-1:0][PRIO_W-1:0] src_prio,
   input  logic [PRIO_W-1:0]              thr,
   output logic [IDX_W-1:0]               win_q,
   output logic                           irq
);
   logic [NUM_SRC-1:0] cand;
   logic [IDX_W-1:0]   best_idx;
   logic [PRIO_W-1:0]  best_prio;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_cand
      if (s == 0) begin : g_rsv
         assign cand[s] = 1'b0;
      end else begin : g_src
         assign cand[s] = src_en[s] && lvl[s] && (src_tgt[s] == TGT[0])
                          && (src_prio[s] > thr);
      end
   end

   // scan downward; ">=" lets lower index take ties
   always_comb begin
      best_idx  = '0;
      best_prio = '0;
      for (int i = NUM_SRC - 1; i > 0; i--) begin
         if (cand[i] && (src_prio[i] >= best_prio)) begin
            best_idx  = IDX_W'(i);
            best_prio = src_prio[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) win_q <= '0;
      else        win_q <= best_idx;
   end

   assign irq = (win_q != '0);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
   parameter int unsigned NUM_SRC  = 71,
   parameter int unsigned NUM_TGT  = 2,
   parameter int unsigned PRIO_W   = 4,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned THR_ADDR = 8'hC0,
   parameter int unsigned VEC_ADDR = 8'hD0,
   localparam int unsigned IDX_W   = $clog2(NUM_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_in,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [DATA_W-1:0]  rdata,
   output logic [NUM_TGT-1:0] irq_out
);
   import irq_pkg::*;

   if (NUM_TGT != 2) begin : g_bad_tgt
      $error("irq_prio_ctrl: target field is one bit, NUM_TGT must be 2");
   end
   if (NUM_SRC < 2 || NUM_SRC > THR_ADDR) begin : g_bad_src
      $error("irq_prio_ctrl: NUM_SRC must fit below THR_ADDR");
   end
   if (PRIO_W > F_EN || DATA_W <= WE_PRIO) begin : g_bad_w
      $error("irq_prio_ctrl: field layout does not fit DATA_W/PRIO_W");
   end
   if (VEC_ADDR < THR_ADDR + NUM_TGT) begin : g_bad_map
      $error("irq_prio_ctrl: register windows overlap");
   end

   logic [NUM_SRC-1:0][PRIO_W-1:0] src_prio;
   logic [NUM_SRC-1:0]             src_en;
   logic [NUM_SRC-1:0]             src_pol;
   logic [NUM_SRC-1:0]             src_tgt;
   logic [NUM_SRC-1:0]             lvl;
   logic [NUM_TGT-1:0][PRIO_W-1:0] thr;
   logic [NUM_TGT-1:0][DATA_W-1:0] base;
   logic [NUM_TGT-1:0][IDX_W-1:0]  win;
   logic [NUM_TGT-1:0][DATA_W-1:0] vec;
   logic [DATA_W-1:0]              rd_mux;

   irq_src_bank #(
      .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .src_prio(src_prio), .src_en(src_en), .src_pol(src_pol), .src_tgt(src_tgt)
   );

   // polarity correction ahead of arbitration
   assign lvl = irq_in ^ src_pol;

   for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
      irq_tgt_cfg #(
         .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
         .THR_ADDR(THR_ADDR + t), .VEC_ADDR(VEC_ADDR + t)
      ) u_cfg (
         .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
         .thr(thr[t]), .base(base[t])
      );

      irq_tgt_arb #(
         .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .TGT(t)
      ) u_arb (
         .clk(clk), .rst_n(rst_n), .lvl(lvl), .src_en(src_en),
         .src_tgt(src_tgt), .src_prio(src_prio), .thr(thr[t]),
         .win_q(win[t]), .irq(irq_out[t])
      );

      assign vec[t] = base[t] + (DATA_W'(win[t]) << VEC_SHIFT);
   end

   always_comb begin
      rd_mux = '0;
      if (addr < ADDR_W'(NUM_SRC)) begin
         for (int s = 0; s < NUM_SRC; s++) begin
            if (addr == ADDR_W'(s)) begin
               rd_mux[PRIO_W-1:0] = src_prio[s];
               rd_mux[F_EN]       = src_en[s];
               rd_mux[F_POL]      = src_pol[s];
               rd_mux[F_TGT]      = src_tgt[s];
            end
         end
      end
      for (int t = 0; t < NUM_TGT; t++) begin
         if (addr == ADDR_W'(THR_ADDR + t)) rd_mux = DATA_W'(thr[t]);
         if (addr == ADDR_W'(VEC_ADDR + t)) rd_mux = vec[t];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_mux;
   end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
   parameter int unsigned NUM_SRC = 71,
   parameter int unsigned NUM_TGT = 2,
   parameter int unsigned PRIO_W  = 4,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 32,
   localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic [NUM_SRC-1:0]             irq_in,
   input logic                           wr_en,
   input logic [ADDR_W-1:0]              addr,
   input logic [DATA_W-1:0]              wdata,
   input logic [NUM_SRC-1:0][PRIO_W-1:0] src_prio,
   input logic [NUM_SRC-1:0]             src_en,
   input logic [NUM_SRC-1:0]             src_pol,
   input logic [NUM_SRC-1:0]             src_tgt,
   input logic [NUM_TGT-1:0][PRIO_W-1:0] thr,
   input logic [NUM_TGT-1:0][IDX_W-1:0]  win,
   input logic [NUM_TGT-1:0]             irq_out
);
   import irq_pkg::*;

   logic [NUM_SRC-1:0][PRIO_W-1:0] p_prio;
   logic [NUM_SRC-1:0]             p_en, p_lvl, p_tgt;
   logic [NUM_TGT-1:0][PRIO_W-1:0] p_thr;
   logic                           src_wr;
   logic [IDX_W-1:0]               a_idx;

   assign src_wr = wr_en && (addr < ADDR_W'(NUM_SRC));
   assign a_idx  = addr[IDX_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p_prio <= '0; p_en <= '0; p_lvl <= '0; p_tgt <= '0; p_thr <= '0;
      end else begin
         p_prio <= src_prio; p_en <= src_en; p_lvl <= irq_in ^ src_pol;
         p_tgt  <= src_tgt;  p_thr <= thr;
      end
   end

   // R4
   prio_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_wr && !wdata[WE_PRIO]) |=> src_prio[$past(a_idx)] == $past(src_prio[a_idx]));
   // R5
   en_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_wr && !wdata[WE_EN]) |=> src_en[$past(a_idx)] == $past(src_en[a_idx]));
   // R6
   pol_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_wr && !wdata[WE_POL]) |=> src_pol[$past(a_idx)] == $past(src_pol[a_idx]));

   for (genvar t = 0; t < NUM_TGT; t++) begin : g_t
      logic [NUM_SRC-1:0] pc;
      logic               any_c, beaten, w_ok;
      always_comb begin
         for (int j = 0; j < NUM_SRC; j++)
            pc[j] = (j != 0) && p_en[j] && p_lvl[j] && (p_tgt[j] == t[0])
                    && (p_prio[j] > p_thr[t]);
         any_c  = |pc;
         w_ok   = pc[win[t]];
         beaten = 1'b0;
         for (int j = 1; j < NUM_SRC; j++)
            if (pc[j] && (j != int'(win[t])) &&
                ((p_prio[j] > p_prio[win[t]]) ||
                 ((p_prio[j] == p_prio[win[t]]) && (j < int'(win[t])))))
               beaten = 1'b1;
      end

      // R7
      win_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq_out[t] |-> w_ok);
      // R8
      win_best_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq_out[t] |-> !beaten);
      // R11
      level_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !any_c |-> !irq_out[t]);
   end
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
   .NUM_SRC(NUM_SRC), .NUM_TGT(NUM_TGT), .PRIO_W(PRIO_W),
   .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .addr(addr),
   .wdata(wdata), .src_prio(src_prio), .src_en(src_en), .src_pol(src_pol),
   .src_tgt(src_tgt), .thr(thr), .win(win), .irq_out(irq_out)
);

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;
   localparam int NS = 71;
   localparam int CLK_P = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [NS-1:0] irq_in = '0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [1:0]  irq_out;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   typedef struct { logic [31:0] exp; string tag; } exp_t;
   exp_t sb[$];

   always #(CLK_P/2) clk = ~clk;

   irq_prio_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // write, then wait until the arbitration register has caught up
   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0;
      @(negedge clk);
   endtask

   // driver: push the expected read value and issue the read
   task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
      exp_t e;
      e.exp = exp; e.tag = tag;
      @(negedge clk); rd_en = 1'b1; addr = a; sb.push_back(e);
      @(negedge clk); rd_en = 1'b0;
   endtask

   // monitor: pop and compare as read data emerges
   initial begin
      forever begin
         @(posedge clk);
         if (rd_en) begin
            #2;
            if (sb.size() == 0) check("monitor underflow", 32'd1, 32'd0);
            else begin
               exp_t e;
               e = sb.pop_front();
               check(e.tag, rdata, e.exp);
            end
         end
      end
   end

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) tick();
      check("R1 irq_out in reset", 32'(irq_out), 32'h0);
      rst_n = 1'b1;
      tick();
      check("R1 irq_out after reset", 32'(irq_out), 32'h0);
      rd(8'd5,  32'h0, "R1 src5 reset");
      rd(8'hC0, 32'h0, "R1 thr0 reset");
      rd(8'hD0, 32'h0, "R1 vec0 reset");

      // source 5: priority 3, enabled, target 0
      wr(8'd5, 32'h1401_0003);
      rd(8'd5, 32'h0001_0003, "R3 src5 readback");
      check("R7 no irq with input low", 32'(irq_out), 32'h0);
      irq_in[5] = 1'b1;
      #1 check("R11 irq still low before edge", 32'(irq_out), 32'h0);
      tick();
      check("R11 irq one clock later", 32'(irq_out), 32'h1);
      rd(8'hD0, 32'd40, "R10 vec0 src5");

      wr(8'd5, 32'h0401_000F);
      rd(8'd5, 32'h0001_0003, "R4 prio locked");
      wr(8'd5, 32'h1000_0007);
      rd(8'd5, 32'h0001_0007, "R5 enable locked");

      // tie at priority 7: lower index wins
      wr(8'd3, 32'h1401_0007);
      irq_in[3] = 1'b1; tick();
      rd(8'hD0, 32'd24, "R8 tie lowest index");
      wr(8'd9, 32'h1401_0009);
      irq_in[9] = 1'b1; tick();
      rd(8'hD0, 32'd72, "R8 highest prio");
      irq_in[9] = 1'b0; tick();
      rd(8'hD0, 32'd24, "R8 fallback after drop");

      // threshold
      wr(8'hC0, 32'd7);
      rd(8'hC0, 32'd7, "R9 thr0 readback");
      check("R7 equal to threshold not delivered", 32'(irq_out), 32'h0);
      rd(8'hD0, 32'd0, "R10 spurious vector is base");
      wr(8'hC0, 32'd6);
      rd(8'hD0, 32'd24, "R9 thr0 lowered");

      // target 1 routing with base
      wr(8'hD1, 32'h0000_1000);
      rd(8'hD1, 32'h0000_1000, "R10 vec1 bare base");
      wr(8'd20, 32'h1701_0002);
      rd(8'd20, 32'h0101_0002, "R3 src20 target readback");
      irq_in[20] = 1'b1; tick();
      check("R9 both targets", 32'(irq_out), 32'h3);
      rd(8'hD1, 32'h0000_10A0, "R10 vec1 src20");
      rd(8'hD0, 32'd24, "R9 target0 unaffected");

      // active-low source 30
      wr(8'd30, 32'h1C03_000C);
      rd(8'd30, 32'h0003_000C, "R12 src30 readback");
      rd(8'hD0, 32'd240, "R12 low input requests");
      irq_in[30] = 1'b1; tick();
      rd(8'hD0, 32'd24, "R12 high input idle");
      wr(8'd30, 32'h0100_0000);
      rd(8'd30, 32'h0003_000C, "R6 target locked");
      wr(8'd30, 32'h0800_0000);
      rd(8'd30, 32'h0001_000C, "R6 polarity unlocked");
      rd(8'hD0, 32'd240, "R6 polarity now active-high");

      // reserved slot 0
      wr(8'd0, 32'h1F01_000F);
      irq_in[0] = 1'b1; tick();
      rd(8'd0, 32'h0, "R2 slot0 reads zero");
      rd(8'hD0, 32'd240, "R2 slot0 never wins");

      // priority 0 never delivered
      wr(8'd40, 32'h1401_0000);
      irq_in = '0; irq_in[0] = 1'b1; irq_in[40] = 1'b1; tick();
      check("R11 outputs drop with no candidate", 32'(irq_out), 32'h0);
      rd(8'hD0, 32'd0, "R7 prio0 not delivered");
      rd(8'hD1, 32'h0000_1000, "R10 vec1 idle base");

      // combined unlock clears all fields
      wr(8'd30, 32'h1E00_0000);
      rd(8'd30, 32'h0, "R3 unlock-all clears");

      repeat (3) tick();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule